// File: doc/BRIEF.md
# Rate-Folding Sample Capture Unit

This unit sits between the probe sampling logic and an external sample memory. On every fast tick it receives one parallel sample of all probe channels. It packs these samples into store words of fixed width, following a selectable speed mode. The modes trade the number of stored channels for finer time resolution. A store word is always four ticks long (one frame). In the full-width mode the frame keeps every channel once, taken from its first tick. The double-rate mode keeps the lower half of the channels at two ticks of the frame. The quad-rate mode keeps the lower quarter of the channels at every tick of the frame.

Each store word goes out on a one-cycle write port together with a wide free-running timestamp. The timestamp counts fast ticks and marks the oldest sample in the word. The trigger logic can gate writes through a store qualifier, or the unit can store every frame. A mode change made in the middle of a frame drops that frame. A synchronous clear restarts both the timestamp and the frame.

Top module: `cap_fold_unit`

## Requirements
- R1: While reset is held, and just after it, `wr_valid`, `wr_data` and `wr_ts` are all zero.
- R2: A frame is four consecutive ticks. The first tick after reset or clear starts a frame. `wr_valid` pulses for exactly one cycle, in the cycle after the frame's fourth tick, and never in two consecutive cycles.
- R3: With `fold_mode` = 2'b00 (full width), `wr_data` equals the whole `probe` word of the frame's first tick.
- R4: With `fold_mode` = 2'b01 (double rate), `wr_data[H-1:0]` holds `probe[H-1:0]` from tick 0 of the frame and `wr_data[NCH-1:H]` holds `probe[H-1:0]` from tick 2, where H = NCH/2. The older sample is in the low half.
- R5: With `fold_mode` = 2'b10 (quad rate), slice j of `wr_data` (bits j*Q up to j*Q+Q-1, Q = NCH/4) holds `probe[Q-1:0]` from tick j of the frame, for j = 0 to 3.
- R6: `wr_ts` equals the tick count of the frame's first tick in every mode. Ticks are counted from 0, starting at the first tick after reset or clear, so `wr_ts` is always a multiple of four.
- R7: `fold_mode` = 2'b11 behaves exactly like full width.
- R8: The mode is taken at a frame's first tick. If `fold_mode` differs from that value at any later tick of the same frame, the frame is not written. The next frame then uses the new value.
- R9: With `gate_en` = 0 every complete frame is written. With `gate_en` = 1 a frame is written only if `store_qual` is high at its fourth tick. A frame that is not written still advances the timestamp.
- R10: A tick with `ts_clr` high produces no write and its sample is discarded. It abandons any partial frame. The following tick has count 0 and starts a new frame.
- R11: The timestamp wraps silently from 2^TS_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock; one probe sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_clr | input | 1 | Synchronous clear of timestamp and frame |
| fold_mode | input | 2 | 00 full width, 01 double rate, 10 quad rate, 11 full width |
| gate_en | input | 1 | 1 = writes gated by store_qual, 0 = store continuously |
| store_qual | input | 1 | Store qualifier from trigger logic |
| probe | input | NCH | Probe channel sample for this tick |
| wr_valid | output | 1 | One-cycle write strobe to sample memory |
| wr_data | output | NCH | Folded store word |
| wr_ts | output | TS_W | Tick count of the oldest sample in the word |

## Verification
Every result here comes from a register that loads at the frame's fourth tick. The write strobe, the word and the timestamp for a frame are therefore due one edge after that tick, and they stay valid for that one cycle only. The bench drives each tick's inputs on the falling edge. At the next falling edge it compares the outputs with expectations built from the sample history of the frame. So each value is checked exactly one edge after the tick that produced it. Drops caused by a mode change, the qualifier or a clear are all checked at that same position as an absent strobe. Wrap-around is checked on a second instance with a narrow timestamp.

// File: rtl/cap_fold_pkg.sv
package cap_fold_pkg;

   localparam int FOLD_DEPTH = 4;

   typedef enum logic [1:0] {
      FOLD_1X  = 2'b00,
      FOLD_2X  = 2'b01,
      FOLD_4X  = 2'b10,
      FOLD_ALT = 2'b11
   } fold_mode_e;

   // tick of the frame at which a lane is filled
   function automatic logic [1:0] lane_load_phase(fold_mode_e m, int lane);
      case (m)
         FOLD_2X: return (lane < 2) ? 2'd0 : 2'd2;
         FOLD_4X: return 2'(lane);
         default: return 2'd0;
      endcase
   endfunction

   // which input lane feeds a given store lane
   function automatic int lane_source(fold_mode_e m, int lane);
      case (m)
         FOLD_2X: return lane % 2;
         FOLD_4X: return 0;
         default: return lane;
      endcase
   endfunction

endpackage

// File: rtl/cap_tick_counter.sv
module cap_tick_counter #(
   parameter int TS_W = 51
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   output logic [TS_W-1:0] ts
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ts <= '0;
      else if (clr) ts <= '0;
      else          ts <= ts + TS_W'(1);
   end
endmodule

// File: rtl/cap_frame_seq.sv
module cap_frame_seq
   import cap_fold_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic [1:0] mode_in,
   output logic [1:0] phase,
   output fold_mode_e mode_cur,
   output logic       frame_ok
);
   fold_mode_e act_q;
   logic       chg_q;
   logic       chg_now;

   always_comb begin
      mode_cur = (phase == 2'd0) ? fold_mode_e'(mode_in) : act_q;
      chg_now  = (phase != 2'd0) && (mode_in != act_q);
      frame_ok = (phase == 2'd3) && !chg_q && !chg_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 2'd0;
         act_q <= FOLD_1X;
         chg_q <= 1'b0;
      end else if (clr) begin
         phase <= 2'd0;
         chg_q <= 1'b0;
      end else begin
         phase <= phase + 2'd1;
         if (phase == 2'd0) begin
            act_q <= fold_mode_e'(mode_in);
            chg_q <= 1'b0;
         end else if (chg_now) begin
            chg_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cap_fold_packer.sv
module cap_fold_packer
   import cap_fold_pkg::*;
#(
   parameter int NCH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     phase,
   input  fold_mode_e     mode_cur,
   input  logic [NCH-1:0] probe,
   output logic [NCH-1:0] word_now
);
   localparam int LW = NCH / FOLD_DEPTH;

   for (genvar g = 0; g < FOLD_DEPTH; g++) begin : g_lane
      logic [LW-1:0] hold_q;
      logic [LW-1:0] slice;
      logic          load;

      always_comb begin
         load  = (phase == lane_load_phase(mode_cur, g));
         slice = probe[lane_source(mode_cur, g)*LW +: LW];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    hold_q <= '0;
         else if (load) hold_q <= slice;
      end

      assign word_now[g*LW +: LW] = load ? slice : hold_q;
   end
endmodule

// File: rtl/cap_fold_unit.sv
module cap_fold_unit
   import cap_fold_pkg::*;
#(
   parameter int NCH  = 16,
   parameter int TS_W = 51
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ts_clr,
   input  logic [1:0]      fold_mode,
   input  logic            gate_en,
   input  logic            store_qual,
   input  logic [NCH-1:0]  probe,
   output logic            wr_valid,
   output logic [NCH-1:0]  wr_data,
   output logic [TS_W-1:0] wr_ts
);
   if (NCH % FOLD_DEPTH != 0 || NCH < FOLD_DEPTH) begin : g_bad_nch
      $error("NCH must be a positive multiple of the fold depth");
   end
   if (TS_W < 2 || TS_W > 64) begin : g_bad_ts
      $error("TS_W must lie between 2 and 64");
   end

   logic [TS_W-1:0] ts_now;
   logic [TS_W-1:0] frame_ts;
   logic [1:0]      seq_phase;
   fold_mode_e      mode_cur;
   logic            frame_ok;
   logic [NCH-1:0]  word_now;
   logic            do_write;

   cap_tick_counter #(.TS_W(TS_W)) u_ticks (
      .clk(clk), .rst_n(rst_n), .clr(ts_clr), .ts(ts_now)
   );

   cap_frame_seq u_seq (
      .clk(clk), .rst_n(rst_n), .clr(ts_clr), .mode_in(fold_mode),
      .phase(seq_phase), .mode_cur(mode_cur), .frame_ok(frame_ok)
   );

   cap_fold_packer #(.NCH(NCH)) u_pack (
      .clk(clk), .rst_n(rst_n), .phase(seq_phase), .mode_cur(mode_cur),
      .probe(probe), .word_now(word_now)
   );

   assign do_write = !ts_clr && frame_ok && (!gate_en || store_qual);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_ts <= '0;
         wr_valid <= 1'b0;
         wr_data  <= '0;
         wr_ts    <= '0;
      end else begin
         wr_valid <= do_write;
         if (!ts_clr && seq_phase == 2'd0) frame_ts <= ts_now;
         if (do_write) begin
            wr_data <= word_now;
            wr_ts   <= frame_ts;
         end
      end
   end
endmodule

module cap_fold_unit_chk #(
   parameter int TS_W = 51
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ts_clr,
   input logic [1:0]      fold_mode,
   input logic            gate_en,
   input logic            store_qual,
   input logic [1:0]      seq_phase,
   input logic            wr_valid,
   input logic [TS_W-1:0] wr_ts
);
   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);
   // R2
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> $past(seq_phase) == 2'd3);
   // R6
   ts_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_ts[1:0] == 2'b00);
   // R8
   mode_change_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_phase == 2'd3 && fold_mode != $past(fold_mode)) |=> !wr_valid);
   // R9
   qual_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_phase == 2'd3 && gate_en && !store_qual) |=> !wr_valid);
   // R10
   clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_clr |=> (!wr_valid && seq_phase == 2'd0));
endmodule

bind cap_fold_unit cap_fold_unit_chk #(.TS_W(TS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ts_clr(ts_clr), .fold_mode(fold_mode),
   .gate_en(gate_en), .store_qual(store_qual), .seq_phase(seq_phase),
   .wr_valid(wr_valid), .wr_ts(wr_ts)
);

// File: tb/test_cap_fold_unit.sv
module test_cap_fold_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 16;
   localparam int TS_W = 51;
   localparam int TSW_SMALL = 5;
   localparam int H = NCH / 2;
   localparam int Q = NCH / 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ts_clr = 1'b0;
   logic [1:0] fold_mode = 2'b00;
   logic gate_en = 1'b0;
   logic store_qual = 1'b0;
   logic [NCH-1:0] probe = '0;
   logic wr_valid, wv_s;
   logic [NCH-1:0] wr_data, wd_s;
   logic [TS_W-1:0] wr_ts;
   logic [TSW_SMALL-1:0] wt_s;

   always #(CLK_PERIOD/2) clk = ~clk;

   cap_fold_unit #(.NCH(NCH), .TS_W(TS_W)) i_cap_fold_unit (
      .clk(clk), .rst_n(rst_n), .ts_clr(ts_clr), .fold_mode(fold_mode),
      .gate_en(gate_en), .store_qual(store_qual), .probe(probe),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ts(wr_ts));

   cap_fold_unit #(.NCH(NCH), .TS_W(TSW_SMALL)) i_wrap (
      .clk(clk), .rst_n(rst_n), .ts_clr(ts_clr), .fold_mode(fold_mode),
      .gate_en(gate_en), .store_qual(store_qual), .probe(probe),
      .wr_valid(wv_s), .wr_data(wd_s), .wr_ts(wt_s));

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference state built from the requirements
   logic [TS_W-1:0] tick = '0;
   logic [1:0] ph = 2'd0;
   logic [1:0] fmode = 2'b00;
   logic [TS_W-1:0] fts = '0;
   logic chg = 1'b0;
   logic [NCH-1:0] smp [4];
   logic exp_v = 1'b0;
   logic [NCH-1:0] exp_d = '0;
   logic [TS_W-1:0] exp_ts = '0;
   string v_tag = "R1";
   string d_tag = "R3";

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired: actual %0d cycles expected under 100000", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [NCH-1:0] fold(logic [1:0] m, logic [NCH-1:0] s0,
         logic [NCH-1:0] s1, logic [NCH-1:0] s2, logic [NCH-1:0] s3);
      case (m)
         2'b01:   return {s2[H-1:0], s0[H-1:0]};
         2'b10:   return {s3[Q-1:0], s2[Q-1:0], s1[Q-1:0], s0[Q-1:0]};
         default: return s0;
      endcase
   endfunction

   function automatic string data_tag(logic [1:0] m);
      case (m)
         2'b01:   return "R4";
         2'b10:   return "R5";
         2'b11:   return "R7";
         default: return "R3";
      endcase
   endfunction

   task automatic check_outputs();
      chk(v_tag, 64'(wr_valid), 64'(exp_v));
      chk(v_tag, 64'(wv_s), 64'(exp_v));
      if (exp_v) begin
         chk(d_tag, 64'(wr_data), 64'(exp_d));
         chk("R6", 64'(wr_ts), 64'(exp_ts));
         chk("R11", 64'(wt_s), 64'(exp_ts[TSW_SMALL-1:0]));
      end
   endtask

   // drive one tick and predict the outputs after its edge
   task automatic apply(logic [NCH-1:0] p, logic [1:0] m, logic g, logic q, logic c);
      probe = p; fold_mode = m; gate_en = g; store_qual = q; ts_clr = c;
      exp_v = 1'b0;
      v_tag = "R2";
      if (c) begin
         tick = '0; ph = 2'd0; chg = 1'b0;
         v_tag = "R10";
         return;
      end
      if (ph == 2'd0) begin
         fmode = m; fts = tick; chg = 1'b0;
      end else if (m != fmode) begin
         chg = 1'b1;
      end
      smp[ph] = p;
      if (ph == 2'd3) begin
         if (chg) v_tag = "R8";
         else if (g && !q) v_tag = "R9";
         exp_v = !chg && (!g || q);
         if (exp_v) begin
            exp_d  = fold(fmode, smp[0], smp[1], smp[2], smp[3]);
            exp_ts = fts;
            d_tag  = data_tag(fmode);
         end
      end
      ph = ph + 2'd1;
      tick = tick + TS_W'(1);
   endtask

   task automatic step(logic [NCH-1:0] p, logic [1:0] m, logic g, logic q, logic c);
      @(negedge clk);
      check_outputs();
      apply(p, m, g, q, c);
   endtask

   task automatic frame(logic [1:0] m, logic [NCH-1:0] a, logic [NCH-1:0] b,
         logic [NCH-1:0] cc, logic [NCH-1:0] d);
      step(a, m, 1'b0, 1'b0, 1'b0);
      step(b, m, 1'b0, 1'b0, 1'b0);
      step(cc, m, 1'b0, 1'b0, 1'b0);
      step(d, m, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      logic [1:0] rm;
      logic rg;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: outputs at reset
      chk("R1", 64'(wr_valid), 64'd0);
      chk("R1", 64'(wr_data), 64'd0);
      chk("R1", 64'(wr_ts), 64'd0);
      rst_n = 1'b1;
      apply(16'h1234, 2'b00, 1'b0, 1'b0, 1'b0);
      step(16'hffff, 2'b00, 1'b0, 1'b0, 1'b0);
      step(16'hffff, 2'b00, 1'b0, 1'b0, 1'b0);
      step(16'hffff, 2'b00, 1'b0, 1'b0, 1'b0);
      // R4, R5, R7: directed fold patterns
      frame(2'b01, 16'h00a5, 16'hffff, 16'h003c, 16'hffff);
      frame(2'b10, 16'h0001, 16'h0002, 16'h0003, 16'h0004);
      frame(2'b11, 16'hbeef, 16'h0000, 16'h1111, 16'h2222);
      // R8: mode change at the third tick drops the frame
      step(16'h5555, 2'b10, 1'b0, 1'b0, 1'b0);
      step(16'h5555, 2'b10, 1'b0, 1'b0, 1'b0);
      step(16'h5555, 2'b01, 1'b0, 1'b0, 1'b0);
      step(16'h5555, 2'b01, 1'b0, 1'b0, 1'b0);
      frame(2'b01, 16'h0f0f, 16'h0, 16'h00f0, 16'h0);
      // R9: gated with qualifier low, then high
      step(16'h7777, 2'b00, 1'b1, 1'b1, 1'b0);
      step(16'h7777, 2'b00, 1'b1, 1'b1, 1'b0);
      step(16'h7777, 2'b00, 1'b1, 1'b1, 1'b0);
      step(16'h7777, 2'b00, 1'b1, 1'b0, 1'b0);
      step(16'h8888, 2'b00, 1'b1, 1'b0, 1'b0);
      step(16'h8888, 2'b00, 1'b1, 1'b0, 1'b0);
      step(16'h8888, 2'b00, 1'b1, 1'b0, 1'b0);
      step(16'h8888, 2'b00, 1'b1, 1'b1, 1'b0);
      // R10: clear in the middle of a frame
      step(16'h9999, 2'b10, 1'b0, 1'b0, 1'b0);
      step(16'h9999, 2'b10, 1'b0, 1'b0, 1'b0);
      step(16'h9999, 2'b10, 1'b0, 1'b0, 1'b1);
      frame(2'b10, 16'h000a, 16'h000b, 16'h000c, 16'h000d);
      // R11: run well past the narrow timestamp wrap, with random traffic
      rm = 2'b00; rg = 1'b0;
      for (int i = 0; i < 1600; i++) begin
         logic [1:0] m;
         logic c;
         if (ph == 2'd0) begin
            rm = 2'($urandom % 4);
            rg = ($urandom % 3) == 0;
         end
         m = rm;
         if (ph != 2'd0 && ($urandom % 24) == 0) m = 2'($urandom % 4);
         c = ($urandom % 97) == 0;
         step(NCH'($urandom), m, rg, 1'($urandom), c);
         rm = (ph == 2'd0) ? rm : m;
      end
      for (int i = 0; i < 4; i++) step('0, 2'b00, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check_outputs();
      summary();
      $finish;
   end
endmodule